// File: doc/BRIEF.md
# Exception Return Target Validator

This block decides where an exception return lands. It reads the saved program status word, the current privilege level and the machine's configuration. From these it works out the privilege level being returned to and whether the return is allowed. It then builds the program counter and the status word that execution resumes with. The saved word may ask for either the narrow 32-bit execution state or the wide 64-bit one. The level is decoded from a different mode encoding in each case, and a fixed set of rules then rejects returns that the configuration cannot honour.

The decision logic is combinational. Its result is captured into output registers one clock after a request strobe, and a one-cycle `done` pulse marks the result. On a rejected return the level stays where it is, the illegal-state flag is raised and execution resumes at the link address. Only the condition flags and the interrupt masks are taken from the saved word. Swapping register banks and saving or restoring stack pointers belong to the surrounding logic.

Top module: `eret_check`

## Requirements
- R1: When bit 4 of `saved_psw` is 0 (wide return), the return is illegal if bit 1 is set or if bits [3:0] equal 1. Otherwise the target level is bits [3:2].
- R2: When bit 4 of `saved_psw` is 1 (narrow return), bits [4:0] decode as follows: 0x10 to level 0; 0x1A to level 2; 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F to level 1. Every other value, 0x16 included, is illegal.
- R3: The return is illegal if the target level is above `cur_lvl`, or if the target is level 2 and `el2_present` is 0.
- R4: For a nonzero target level t, the return is illegal if `lvl_wide[t]` (1 = wide) differs from the width the saved word asks for (wide when bit 4 is 0).
- R5: The return is illegal if the target is level 2 while `secure` is 1 and `cur_lvl` is not 3. It is also illegal if the target is level 1 while `tge` is 1, unless `secure` is 1 and `cur_lvl` is not 3.
- R6: On a legal narrow return, `new_pc` is `link_addr` with bit 0 cleared when Thumb bit 5 of `saved_psw` is set, and with bits [1:0] cleared otherwise. On a legal wide return, `new_pc` equals `link_addr`.
- R7: On a legal return, `tgt_lvl` is the decoded level, `illegal` is 0, and `new_psw` equals `saved_psw`, apart from bit 21 (see R9).
- R8: On an illegal return, `illegal` is 1 and `tgt_lvl` equals `cur_lvl`. `new_pc` equals `link_addr`. `new_psw` takes bits [31:28] and [9:6] from `saved_psw` and all other bits from `cur_psw`, and then has bit 20 set.
- R9: Single-step bit 21 of `new_psw` keeps its source value only if `step_lvl[L]` is 1, where L is the resulting level. Otherwise it is 0.
- R10: The outputs update on the clock edge after `req` is sampled high and hold until the next request. `done` is high for exactly the cycle after each request. All outputs are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Evaluate a return this cycle |
| saved_psw | input | 32 | Saved status word being returned to |
| cur_lvl | input | 2 | Current privilege level |
| secure | input | 1 | Processor is in secure state |
| el2_present | input | 1 | Level 2 is implemented |
| lvl_wide | input | 4 | Per level: 1 if that level runs in the wide state |
| tge | input | 1 | Trap-general control: routes level-1 work to level 2 |
| step_lvl | input | 4 | Per level: single-step is active at that level |
| link_addr | input | AW | Return address |
| cur_psw | input | 32 | Current status word |
| done | output | 1 | Result valid pulse |
| tgt_lvl | output | 2 | Resulting level |
| illegal | output | 1 | Return was rejected |
| new_pc | output | AW | Program counter to resume at |
| new_psw | output | 32 | Status word to resume with |

## Verification
The embedded assertions run on every cycle. They check the request-to-done timing, and that a rejected return keeps the current level, resumes at the unmodified link address and raises the illegal flag. They also check that an accepted return never raises the level and yields an aligned narrow PC. Which rule rejects which request can only be shown by the bench. The same holds for the exact mode decoding in both widths, the field-by-field merge of the status word and the per-level single-step rule. The bench sweeps every 5-bit mode value against every current level, security state, level-2 presence, trap-general setting and per-level width map.

// File: rtl/eret_check.sv
module eret_check #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [31:0]   saved_psw,
  input  logic [1:0]    cur_lvl,
  input  logic          secure,
  input  logic          el2_present,
  input  logic [3:0]    lvl_wide,
  input  logic          tge,
  input  logic [3:0]    step_lvl,
  input  logic [AW-1:0] link_addr,
  input  logic [31:0]   cur_psw,
  output logic          done,
  output logic [1:0]    tgt_lvl,
  output logic          illegal,
  output logic [AW-1:0] new_pc,
  output logic [31:0]   new_psw
);

  localparam int          STEP_BIT  = 21;
  localparam int          ILL_BIT   = 20;
  localparam int          THUMB_BIT = 5;
  localparam int          NARROW_BIT = 4;
  localparam logic [31:0] KEEP_MASK = 32'hF000_03C0;

  logic       narrow;
  logic       dec_bad;
  logic [1:0] dec_lvl;

  assign narrow = saved_psw[NARROW_BIT];

  always_comb begin
    dec_bad = 1'b0;
    dec_lvl = 2'd0;
    if (narrow) begin
      case (saved_psw[4:0])
        5'h10: dec_lvl = 2'd0;
        5'h1A: dec_lvl = 2'd2;
        5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F: dec_lvl = 2'd1;
        default: dec_bad = 1'b1;
      endcase
    end else if (saved_psw[1] || saved_psw[3:0] == 4'd1) begin
      dec_bad = 1'b1;
    end else begin
      dec_lvl = saved_psw[3:2];
    end
  end

  logic sec_low, r_above, r_noel2, r_width, r_sec2, r_tge, bad;

  assign sec_low = secure && (cur_lvl != 2'd3);
  assign r_above = dec_lvl > cur_lvl;
  assign r_noel2 = (dec_lvl == 2'd2) && !el2_present;
  assign r_width = (dec_lvl != 2'd0) && (lvl_wide[dec_lvl] == narrow);
  assign r_sec2  = (dec_lvl == 2'd2) && sec_low;
  assign r_tge   = (dec_lvl == 2'd1) && tge && !sec_low;
  assign bad     = dec_bad | r_above | r_noel2 | r_width | r_sec2 | r_tge;

  logic [1:0]    res_lvl;
  logic [AW-1:0] res_pc;
  logic [AW-1:0] pc_mask;
  logic [31:0]   merged;
  logic [31:0]   res_psw;

  assign res_lvl = bad ? cur_lvl : dec_lvl;
  assign pc_mask = saved_psw[THUMB_BIT] ? ~AW'(1) : ~AW'(3);
  assign res_pc  = (!bad && narrow) ? (link_addr & pc_mask) : link_addr;
  assign merged  = bad ? ((cur_psw & ~KEEP_MASK) | (saved_psw & KEEP_MASK) | (32'd1 << ILL_BIT))
                       : saved_psw;

  always_comb begin
    res_psw = merged;
    res_psw[STEP_BIT] = merged[STEP_BIT] & step_lvl[res_lvl];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      tgt_lvl <= 2'd0;
      illegal <= 1'b0;
      new_pc  <= '0;
      new_psw <= '0;
    end else begin
      done <= req;
      if (req) begin
        tgt_lvl <= res_lvl;
        illegal <= bad;
        new_pc  <= res_pc;
        new_psw <= res_psw;
      end
    end
  end

  // R10
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  // R10
  done_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req));
  // R8
  ill_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (tgt_lvl == $past(cur_lvl) && new_pc == $past(link_addr)
                           && new_psw[ILL_BIT]));
  // R3
  legal_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (tgt_lvl <= $past(cur_lvl)));
  // R6
  narrow_pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && $past(saved_psw[NARROW_BIT])) |-> (new_pc[0] == 1'b0));

endmodule

// File: tb/eret_check_tb.sv
`timescale 1ns/1ps
module eret_check_tb;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [31:0]   saved_psw = '0;
  logic [1:0]    cur_lvl = '0;
  logic          secure = 1'b0;
  logic          el2_present = 1'b0;
  logic [3:0]    lvl_wide = '0;
  logic          tge = 1'b0;
  logic [3:0]    step_lvl = '0;
  logic [AW-1:0] link_addr = '0;
  logic [31:0]   cur_psw = '0;
  logic          done, illegal;
  logic [1:0]    tgt_lvl;
  logic [AW-1:0] new_pc;
  logic [31:0]   new_psw;

  int checks = 0;
  int fails  = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  eret_check #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .saved_psw(saved_psw), .cur_lvl(cur_lvl),
    .secure(secure), .el2_present(el2_present), .lvl_wide(lvl_wide), .tge(tge),
    .step_lvl(step_lvl), .link_addr(link_addr), .cur_psw(cur_psw), .done(done),
    .tgt_lvl(tgt_lvl), .illegal(illegal), .new_pc(new_pc), .new_psw(new_psw));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(output bit ill, output logic [1:0] lvl, output logic [63:0] pc,
                       output logic [31:0] psw, output string why);
    int t;
    bit nar;
    t = -1;
    nar = saved_psw[4];
    why = "R7";
    if (nar) begin
      if (saved_psw[4:0] == 5'h10) t = 0;
      else if (saved_psw[4:0] == 5'h1A) t = 2;
      else if (saved_psw[4:0] inside {5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F}) t = 1;
      if (t < 0) why = "R2";
    end else begin
      if (saved_psw[1] == 1'b0 && saved_psw[3:0] != 4'd1) t = int'(saved_psw[3:2]);
      else why = "R1";
    end
    ill = (t < 0);
    if (!ill && (t > int'(cur_lvl) || (t == 2 && !el2_present))) begin ill = 1; why = "R3"; end
    if (!ill && t != 0 && lvl_wide[t] != !nar) begin ill = 1; why = "R4"; end
    if (!ill && t == 2 && secure && cur_lvl != 3) begin ill = 1; why = "R5"; end
    if (!ill && t == 1 && tge && !(secure && cur_lvl != 3)) begin ill = 1; why = "R5"; end
    if (ill) begin
      lvl = cur_lvl;
      pc = link_addr;
      psw = (cur_psw & 32'h0FFF_FC3F) | (saved_psw & 32'hF000_03C0);
      psw[20] = 1'b1;
    end else begin
      lvl = 2'(t);
      pc = link_addr;
      if (nar) pc = saved_psw[5] ? {link_addr[63:1], 1'b0} : {link_addr[63:2], 2'b00};
      psw = saved_psw;
    end
    if (!step_lvl[lvl]) psw[21] = 1'b0;
  endtask

  task automatic run_all();
    bit ill_e;
    logic [1:0] lvl_e;
    logic [63:0] pc_e;
    logic [31:0] psw_e;
    string why;
    @(negedge clk);
    check(done == 0 && illegal == 0 && tgt_lvl == 0 && new_pc == 0 && new_psw == 0,
          "R10 reset state", {new_pc[31:0], new_psw}, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 32; m++)
      for (int cl = 0; cl < 4; cl++)
        for (int s = 0; s < 2; s++)
          for (int e = 0; e < 2; e++)
            for (int g = 0; g < 2; g++)
              for (int w = 0; w < 16; w++) begin
                seed = seed ^ (seed << 13);
                seed = seed ^ (seed >> 7);
                seed = seed ^ (seed << 17);
                @(negedge clk);
                saved_psw = {seed[63:37], 5'(m)};
                cur_lvl = 2'(cl);
                secure = s[0];
                el2_present = e[0];
                tge = g[0];
                lvl_wide = 4'(w);
                step_lvl = seed[3:0];
                link_addr = {seed[31:0], seed[63:32]};
                cur_psw = seed[47:16];
                req = 1'b1;
                model(ill_e, lvl_e, pc_e, psw_e, why);
                @(negedge clk);
                req = 1'b0;
                check(done == 1'b1, "R10 done after req", done, 1);
                check(illegal == ill_e, {why, " illegal decision"}, illegal, ill_e);
                check(tgt_lvl == lvl_e, ill_e ? "R8 level kept" : {why, " target level"},
                      tgt_lvl, lvl_e);
                check(new_pc == pc_e, ill_e ? "R8 pc" : "R6 pc", new_pc, pc_e);
                check(new_psw[31:22] == psw_e[31:22] && new_psw[20:0] == psw_e[20:0],
                      ill_e ? "R8 status merge" : "R7 status copy", new_psw, psw_e);
                check(new_psw[21] == psw_e[21], "R9 single-step bit", new_psw[21], psw_e[21]);
                if (m == 0 && cl == 0 && w == 0) begin
                  @(negedge clk);
                  check(done == 1'b0 && new_pc == pc_e, "R10 pulse ends, outputs hold",
                        {63'd0, done}, 0);
                end
              end
  endtask

  initial begin
    fork
      run_all();
      begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule